// File: doc/BRIEF.md
# UART DMA Request Generator

This block drives the two active-low DMA request lines of a FIFO-based UART: one that tells a DMA engine received characters are waiting, and one that tells it the transmitter can take characters. It reads the fill counts of both FIFOs, a trigger-level flag and a receive-timeout pulse from the receive path, and two control bits. One control bit enables the FIFOs. The other asks for burst signalling.

In single-transfer signalling (mode 0), each request simply follows whether there is work for one transfer. In burst signalling (mode 1), the requests have hysteresis:

- The receive request waits for the trigger level or a timeout, then holds until the receive FIFO is drained.
- The transmit request asserts on an empty FIFO and holds until the FIFO is full.

Burst signalling is only possible while the FIFOs are enabled. With the FIFOs off, the block always uses mode 0.

All pins are plain control and status signals. No data passes through the block, so there is no valid/ready interface and no back-pressure. The fill counts are levels sampled on every clock. Both outputs are registered and respond on the clock edge after their inputs change.

Top module: `uart_dma_req`

## Requirements
- R1: While reset is asserted, and on the first edge after it, `rx_req_n` and `tx_req_n` are high (inactive).
- R2: Burst signalling applies only when `fifo_en`=1 and `burst_sel`=1. Every other combination, including `fifo_en`=0 with `burst_sel`=1, behaves as single-transfer signalling.
- R3: In single-transfer signalling, after each edge `rx_req_n` is 0 if `rx_count` was at least 1 at that edge, and 1 if it was 0.
- R4: In burst signalling, with `rx_count` nonzero, `rx_trig_hit`=1 or `rx_timeout`=1 at an edge drives `rx_req_n` to 0 after that edge.
- R5: In burst signalling, an inactive `rx_req_n` stays 1 while the receive FIFO is nonempty and neither the trigger flag nor the timeout is present.
- R6: In burst signalling, an active `rx_req_n` stays 0 while `rx_count` is nonzero, even after the trigger flag drops. It returns to 1 on the edge after `rx_count` is 0.
- R7: In single-transfer signalling, after each edge `tx_req_n` is 0 if `tx_count` was 0, and 1 if `tx_count` was at least 1.
- R8: In burst signalling, `tx_req_n` goes to 0 after an edge where `tx_count` is 0. It stays 0 until an edge where `tx_count` equals TX_DEPTH, after which it is 1.
- R9: In burst signalling, an inactive `tx_req_n` stays 1 while `tx_count` is between 1 and TX_DEPTH, and re-asserts only when the FIFO is empty.
- R10: A change of `fifo_en` or `burst_sel` takes effect on the next edge. The current request state carries over into the new mode's rules.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| fifo_en | input | 1 | FIFOs enabled; 0 forces single-transfer signalling |
| burst_sel | input | 1 | 1 requests burst signalling |
| rx_count | input | $clog2(RX_DEPTH+1) | Characters held in the receive FIFO or holding register |
| rx_trig_hit | input | 1 | Receive fill is at or above its trigger level |
| rx_timeout | input | 1 | Receive character timeout event |
| tx_count | input | $clog2(TX_DEPTH+1) | Characters held in the transmit FIFO or holding register |
| rx_req_n | output | 1 | Receive DMA request, active low |
| tx_req_n | output | 1 | Transmit DMA request, active low |

## Verification
The properties assume both fill counts never exceed their FIFO depths. They also assume the trigger flag and the timeout only matter while the receive count is nonzero: an empty receive FIFO always wins.

The stimulus drives counts only within 0..DEPTH and changes every input on the falling clock edge. A behavioural model in the bench predicts both outputs each cycle from the request history. The sequences cover:
- the trigger dropping while data remains;
- a partly filled transmit FIFO after the request has released;
- mode flips in both directions while a request is held.

// File: rtl/uart_dma_pkg.sv
package uart_dma_pkg;

  typedef enum logic {
    DMA_SINGLE = 1'b0,
    DMA_BURST  = 1'b1
  } dma_mode_e;

endpackage

// File: rtl/uart_dma_mode_sel.sv
module uart_dma_mode_sel
  import uart_dma_pkg::*;
(
  input  logic      fifo_en,
  input  logic      burst_sel,
  output dma_mode_e mode
);

  // Burst signalling needs the FIFOs; character mode is always single.
  always_comb begin
    if (fifo_en && burst_sel) mode = DMA_BURST;
    else                      mode = DMA_SINGLE;
  end

endmodule

// File: rtl/uart_dma_rx_req.sv
module uart_dma_rx_req
  import uart_dma_pkg::*;
#(
  parameter  int DEPTH = 16,
  localparam int CW    = $clog2(DEPTH + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  dma_mode_e     mode,
  input  logic [CW-1:0] count,
  input  logic          trig_hit,
  input  logic          timeout,
  output logic          req_n
);

  logic act_q, act_d, has_data;

  assign has_data = (count != '0);

  always_comb begin
    case (mode)
      DMA_SINGLE: act_d = has_data;
      DMA_BURST: begin
        if (!has_data)  act_d = 1'b0;
        else if (act_q) act_d = 1'b1;
        else            act_d = trig_hit | timeout;
      end
      default:    act_d = has_data;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) act_q <= 1'b0;
    else        act_q <= act_d;
  end

  assign req_n = ~act_q;

endmodule

// File: rtl/uart_dma_tx_req.sv
module uart_dma_tx_req
  import uart_dma_pkg::*;
#(
  parameter  int DEPTH = 16,
  localparam int CW    = $clog2(DEPTH + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  dma_mode_e     mode,
  input  logic [CW-1:0] count,
  output logic          req_n
);

  localparam logic [CW-1:0] FULL_LVL = CW'(DEPTH);

  logic act_q, act_d, empty, full;

  assign empty = (count == '0);
  assign full  = (count >= FULL_LVL);

  always_comb begin
    case (mode)
      DMA_SINGLE: act_d = empty;
      DMA_BURST: begin
        if (full)       act_d = 1'b0;
        else if (act_q) act_d = 1'b1;
        else            act_d = empty;
      end
      default:    act_d = empty;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) act_q <= 1'b0;
    else        act_q <= act_d;
  end

  assign req_n = ~act_q;

endmodule

// File: rtl/uart_dma_req.sv
module uart_dma_req
  import uart_dma_pkg::*;
#(
  parameter  int RX_DEPTH = 16,
  parameter  int TX_DEPTH = 16,
  localparam int RX_CW    = $clog2(RX_DEPTH + 1),
  localparam int TX_CW    = $clog2(TX_DEPTH + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             fifo_en,
  input  logic             burst_sel,
  input  logic [RX_CW-1:0] rx_count,
  input  logic             rx_trig_hit,
  input  logic             rx_timeout,
  input  logic [TX_CW-1:0] tx_count,
  output logic             rx_req_n,
  output logic             tx_req_n
);

  dma_mode_e mode;

  uart_dma_mode_sel u_mode (
    .fifo_en   (fifo_en),
    .burst_sel (burst_sel),
    .mode      (mode)
  );

  uart_dma_rx_req #(.DEPTH(RX_DEPTH)) u_rx (
    .clk      (clk),
    .rst_n    (rst_n),
    .mode     (mode),
    .count    (rx_count),
    .trig_hit (rx_trig_hit),
    .timeout  (rx_timeout),
    .req_n    (rx_req_n)
  );

  uart_dma_tx_req #(.DEPTH(TX_DEPTH)) u_tx (
    .clk   (clk),
    .rst_n (rst_n),
    .mode  (mode),
    .count (tx_count),
    .req_n (tx_req_n)
  );

endmodule

// File: rtl/uart_dma_req_chk.sv
module uart_dma_req_chk #(
  parameter  int RX_DEPTH = 16,
  parameter  int TX_DEPTH = 16,
  localparam int RX_CW    = $clog2(RX_DEPTH + 1),
  localparam int TX_CW    = $clog2(TX_DEPTH + 1)
) (
  input logic             clk,
  input logic             rst_n,
  input logic             fifo_en,
  input logic             burst_sel,
  input logic [RX_CW-1:0] rx_count,
  input logic             rx_trig_hit,
  input logic             rx_timeout,
  input logic [TX_CW-1:0] tx_count,
  input logic             rx_req_n,
  input logic             tx_req_n
);

  logic burst;
  assign burst = fifo_en && burst_sel;

  // R1: inactive while in reset
  always @(posedge clk) begin
    if (!rst_n) a_r1_reset_idle: assert (rx_req_n && tx_req_n);
  end

  // R3, R2: single-transfer receive follows occupancy
  a_r3_rx_single_assert: assert property (@(posedge clk) disable iff (!rst_n)
    (!burst && rx_count != '0) |=> !rx_req_n);

  // R6: an empty receive FIFO always releases the request
  a_r6_rx_empty_release: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_count == '0) |=> rx_req_n);

  // R4: trigger or timeout in burst mode asserts
  a_r4_rx_burst_start: assert property (@(posedge clk) disable iff (!rst_n)
    (burst && rx_count != '0 && (rx_trig_hit || rx_timeout)) |=> !rx_req_n);

  // R5: no spontaneous receive request in burst mode
  a_r5_rx_burst_wait: assert property (@(posedge clk) disable iff (!rst_n)
    (burst && rx_req_n && !rx_trig_hit && !rx_timeout) |=> rx_req_n);

  // R6: burst receive request holds while data remains
  a_r6_rx_burst_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (burst && !rx_req_n && rx_count != '0) |=> !rx_req_n);

  // R7: single-transfer transmit releases once written
  a_r7_tx_single_release: assert property (@(posedge clk) disable iff (!rst_n)
    (!burst && tx_count != '0) |=> tx_req_n);

  // R8: an empty transmit FIFO always requests
  a_r8_tx_empty_assert: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_count == '0) |=> !tx_req_n);

  // R8: a full transmit FIFO always releases
  a_r8_tx_full_release: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_count == TX_CW'(TX_DEPTH)) |=> tx_req_n);

  // R9: burst transmit stays released while partly filled
  a_r9_tx_burst_wait: assert property (@(posedge clk) disable iff (!rst_n)
    (burst && tx_req_n && tx_count != '0) |=> tx_req_n);

  // R8: burst transmit holds until full
  a_r8_tx_burst_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (burst && !tx_req_n && tx_count != TX_CW'(TX_DEPTH)) |=> !tx_req_n);

endmodule

bind uart_dma_req uart_dma_req_chk #(.RX_DEPTH(RX_DEPTH), .TX_DEPTH(TX_DEPTH)) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .fifo_en     (fifo_en),
  .burst_sel   (burst_sel),
  .rx_count    (rx_count),
  .rx_trig_hit (rx_trig_hit),
  .rx_timeout  (rx_timeout),
  .tx_count    (tx_count),
  .rx_req_n    (rx_req_n),
  .tx_req_n    (tx_req_n)
);

// File: tb/uart_dma_req_bench.sv
module uart_dma_req_bench;

  localparam int RXD = 16;
  localparam int TXD = 16;
  localparam int RXW = $clog2(RXD + 1);
  localparam int TXW = $clog2(TXD + 1);

  logic           clk = 1'b0;
  logic           rst_n = 1'b0;
  logic           fifo_en = 1'b0, burst_sel = 1'b0;
  logic [RXW-1:0] rx_count = '0;
  logic           rx_trig_hit = 1'b0, rx_timeout = 1'b0;
  logic [TXW-1:0] tx_count = '0;
  logic           rx_req_n, tx_req_n;

  int checks = 0;
  int fails  = 0;
  int cycles = 0;
  bit m_rx_act = 0;
  bit m_tx_act = 0;
  string tag = "R1";

  always #4 clk = ~clk;

  uart_dma_req #(.RX_DEPTH(RXD), .TX_DEPTH(TXD)) u_uart_dma_req (
    .clk(clk), .rst_n(rst_n), .fifo_en(fifo_en), .burst_sel(burst_sel),
    .rx_count(rx_count), .rx_trig_hit(rx_trig_hit), .rx_timeout(rx_timeout),
    .tx_count(tx_count), .rx_req_n(rx_req_n), .tx_req_n(tx_req_n)
  );

  always @(posedge clk) begin
    cycles++;
    if (cycles > 20000) begin
      fails++;
      $display("FAIL watchdog: run hung, actual %0d cycles expected < 20000", cycles);
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  task automatic check(input string t, input logic act, input logic exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s at %0t: actual %b expected %b", t, $time, act, exp);
    end
  endtask

  // Apply inputs on the falling edge, predict, and compare after the rising edge.
  task automatic step(input bit fe, input bit bs, input int rc, input bit trg,
                      input bit tmo, input int tc);
    bit burst;
    @(negedge clk);
    fifo_en = fe; burst_sel = bs; rx_count = RXW'(rc);
    rx_trig_hit = trg; rx_timeout = tmo; tx_count = TXW'(tc);
    burst = fe && bs;
    if (!burst)              m_rx_act = (rc > 0);
    else if (rc == 0)        m_rx_act = 0;
    else if (!m_rx_act)      m_rx_act = trg || tmo;
    if (!burst)              m_tx_act = (tc == 0);
    else if (tc >= TXD)      m_tx_act = 0;
    else if (!m_tx_act)      m_tx_act = (tc == 0);
    @(posedge clk);
    #1;
    check({tag, " rx_req_n"}, rx_req_n, ~m_rx_act);
    check({tag, " tx_req_n"}, tx_req_n, ~m_tx_act);
  endtask

  initial begin
    // R1: reset state, with busy-looking inputs
    tx_count = 5; rx_count = 3;
    repeat (3) @(posedge clk);
    #1;
    check("R1 rx_req_n in reset", rx_req_n, 1'b1);
    check("R1 tx_req_n in reset", tx_req_n, 1'b1);
    @(negedge clk); rst_n = 1'b1;
    tag = "R1";  step(0, 0, 0, 0, 0, 3);

    // R3 / R7: single-transfer signalling
    tag = "R3";  step(1, 0, 1, 0, 0, 3);
    step(1, 0, 5, 0, 0, 3);
    step(1, 0, 0, 0, 0, 3);
    tag = "R7";  step(1, 0, 0, 0, 0, 0);
    step(1, 0, 0, 0, 0, 1);
    step(1, 0, 0, 0, 0, 0);

    // R2: burst select ignored with FIFOs off
    tag = "R2";  step(0, 1, 1, 0, 0, 0);
    step(0, 1, 1, 0, 0, 1);
    step(0, 1, 0, 0, 0, 1);

    // R5 / R4 / R6: burst receive
    tag = "R5";  step(1, 1, 3, 0, 0, 16);
    step(1, 1, 7, 0, 0, 16);
    tag = "R4";  step(1, 1, 8, 1, 0, 16);
    tag = "R6";  step(1, 1, 6, 0, 0, 16);
    step(1, 1, 1, 0, 0, 16);
    step(1, 1, 0, 0, 0, 16);
    step(1, 1, 2, 0, 0, 16);
    tag = "R4";  step(1, 1, 2, 0, 1, 16);
    tag = "R6";  step(1, 1, 2, 0, 0, 16);
    step(1, 1, 0, 1, 0, 16);

    // R8 / R9: burst transmit
    tag = "R8";  step(1, 1, 0, 0, 0, 0);
    step(1, 1, 0, 0, 0, 5);
    step(1, 1, 0, 0, 0, 15);
    step(1, 1, 0, 0, 0, 16);
    tag = "R9";  step(1, 1, 0, 0, 0, 10);
    step(1, 1, 0, 0, 0, 1);
    tag = "R8";  step(1, 1, 0, 0, 0, 0);
    step(1, 1, 0, 0, 0, 9);

    // R10: mode changes carry request state
    tag = "R10"; step(1, 0, 4, 0, 0, 9);
    step(1, 1, 4, 0, 0, 9);
    step(1, 1, 4, 0, 0, 9);
    step(0, 1, 4, 0, 0, 0);
    step(1, 1, 4, 0, 0, 3);
    step(1, 1, 0, 0, 0, 3);
    step(1, 1, 3, 0, 0, 3);
    step(1, 0, 3, 0, 0, 3);

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

endmodule